// File: doc/BRIEF.md
# Serial Register Port with Command-Byte Gatekeeping

This block is the device-side serial front end of a converter core. A host reaches four internal registers (command/status, setup, test and result) over a four-wire serial link: serial clock, data in, data out and an active-low select. Every access has two phases. The host first sends a command byte. That byte names the target register and says whether the following phase reads or writes it. The host then moves the register contents. The command byte also carries two live control fields, operating gain and standby, which go straight out to the core.

The core delivers a conversion word with a one-cycle valid strobe. The block keeps that word and raises a ready flag, which the host sees as the top bit of the command/status register. Reading the whole result word clears the flag, unless a newer result arrived while the read was in progress. All logic runs on the system clock. The serial inputs pass through a synchronizer and are edge-detected, so the serial clock must be several system clocks slower.

The controller has three states. CMD_WAIT accepts a command byte. REG_WRITE shifts in the contents of the selected register. REG_READ shifts the selected register out. The transitions are:
- Issue-write: CMD_WAIT to REG_WRITE.
- Issue-read: CMD_WAIT to REG_READ.
- Stay: CMD_WAIT to CMD_WAIT, taken on a rejected byte or a command that targets the command register for writing.
- Finish: REG_WRITE or REG_READ back to CMD_WAIT after the last bit.
- Abort: any state to CMD_WAIT when select is released mid-byte.

Top module: `regport_top`

## Requirements
- R1: After reset, gain is 0, standby is 0 and all setup fields are 0. The ready flag is clear and `sdo` is low. The first byte after reset is taken as a command byte.
- R2: Command byte layout: bit 6 must be 0, bits 5:4 select the register (00 command/status, 01 setup, 10 test, 11 result), bit 3 = 1 means the next phase reads, bit 2 is standby and bits 1:0 are gain. Every accepted command updates standby and gain. A byte with bit 6 = 1 is ignored entirely and the block keeps waiting for a command.
- R3: The setup register is 8 bits. Bits 7:6 drive `cal_mode`, bit 5 drives `unipolar` and bits 4:0 drive `filt_sel`. It reads back unchanged.
- R4: The test register is 8 bits, written and read back unchanged. It drives no output.
- R5: Reading the command/status register returns {ready, 0, select, 1, standby, gain}, taking the values set by the command byte that requested the read.
- R6: The result register is read as 16 bits. Reading all 16 bits clears the ready flag. Bits are shifted MSB first on `sdi` and `sdo`: input is sampled on the rising serial edge and output changes on the falling serial edge.
- R7: A result that arrives during a result read does not change the word being shifted out. The ready flag stays set after that read, and the next read returns the new result.
- R8: Releasing select mid-byte discards the partial bits. The next byte is then taken as a command byte.
- R9: When the selected transfer completes, the block expects a command byte again, also within one continuous select frame.
- R10: A write phase aimed at the result register is 16 bits long and has no effect on the stored result.
- R11: `sdo` is low outside a read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host, idles high |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| res_valid | input | 1 | One-cycle strobe: new conversion result |
| res_data | input | RES_W | Conversion result |
| gain | output | 2 | Operating gain from command byte |
| standby | output | 1 | Standby request from command byte |
| cal_mode | output | 2 | Calibration mode from setup register |
| unipolar | output | 1 | Unipolar (1) / bipolar (0) select |
| filt_sel | output | 5 | Filter selection from setup register |

## Verification
A vector table drives write-then-read pairs to each register. This separates a wrong register select from a wrong field position. The write phases also check that `sdo` stays low. Directed sequences then cover the result path: a plain result read, and a result landing four bits into a read. The second case tells a shifted copy of the word apart from a live one, and a lost ready flag apart from a kept one. Further sequences cover a bit-6 byte, a three-bit aborted frame and back-to-back phases in one frame. A frame misaligned by a missed return to command waiting shows up as a wrong read-back value.

// File: rtl/regport_pkg.sv
package regport_pkg;
    typedef enum logic [1:0] {
        CMD_WAIT  = 2'd0,
        REG_WRITE = 2'd1,
        REG_READ  = 2'd2
    } fsm_t;

    typedef enum logic [1:0] {
        SEL_CMD   = 2'b00,
        SEL_SETUP = 2'b01,
        SEL_TEST  = 2'b10,
        SEL_RES   = 2'b11
    } sel_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdi,
    input  logic cs_n,
    output logic sdi_s,
    output logic sel_s,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sclk_p, sdi_p, csn_p;
    logic              sclk_d;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sclk_p[i] <= 1'b1;
                    sdi_p[i]  <= 1'b0;
                    csn_p[i]  <= 1'b1;
                end else if (i == 0) begin
                    sclk_p[i] <= sclk;
                    sdi_p[i]  <= sdi;
                    csn_p[i]  <= cs_n;
                end else begin
                    sclk_p[i] <= sclk_p[i-1];
                    sdi_p[i]  <= sdi_p[i-1];
                    csn_p[i]  <= csn_p[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= sclk_p[STAGES-1];
    end

    assign sdi_s = sdi_p[STAGES-1];
    assign sel_s = ~csn_p[STAGES-1];
    assign rise  = sel_s &  sclk_p[STAGES-1] & ~sclk_d;
    assign fall  = sel_s & ~sclk_p[STAGES-1] &  sclk_d;
endmodule

// File: rtl/regport_result.sv
module regport_result #(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_in,
    input  logic             rd_start,
    input  logic             rd_done,
    output logic             drdy,
    output logic [RES_W-1:0] res_word
);
    logic fresh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drdy     <= 1'b0;
            fresh    <= 1'b0;
            res_word <= '0;
        end else begin
            if (res_valid) begin
                res_word <= res_in;
                drdy     <= 1'b1;
                fresh    <= 1'b1;
            end else begin
                if (rd_start)                drdy  <= drdy;
                if (rd_start)                fresh <= 1'b0;
                if (rd_done && !fresh)       drdy  <= 1'b0;
            end
        end
    end

    // R6
    rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !fresh && !res_valid) |=> !drdy);
    // R7
    rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (drdy && res_word == $past(res_in)));
endmodule

// File: rtl/regport_ctrl.sv
module regport_ctrl
    import regport_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdi_s,
    input  logic             sel_s,
    input  logic             rise,
    input  logic             fall,
    input  logic             drdy,
    input  logic [RES_W-1:0] res_word,
    output logic             sdo,
    output logic [1:0]       gain,
    output logic             standby,
    output logic [7:0]       setup,
    output logic             rd_start,
    output logic             rd_done
);
    localparam int CW  = $clog2(RES_W + 1);
    localparam int PAD = RES_W - BYTE_W;

    fsm_t             state, nxt;
    sel_t             rsel;
    logic [CW-1:0]    cnt, len_m1;
    logic [RES_W-1:0] sh;
    logic [7:0]       test_q, byte_in, cmd_rb;
    logic             sdo_q, last, byte_bad, cmd_loop;

    assign byte_in  = {sh[6:0], sdi_s};
    assign len_m1   = (state != CMD_WAIT && rsel == SEL_RES) ? CW'(RES_W - 1) : CW'(BYTE_W - 1);
    assign last     = rise && (cnt == len_m1);
    assign byte_bad = byte_in[6];
    assign cmd_loop = (sel_t'(byte_in[5:4]) == SEL_CMD) && !byte_in[3];
    assign cmd_rb   = {drdy, 1'b0, byte_in[5:4], 1'b1, byte_in[2:0]};

    always_comb begin
        nxt = state;
        if (!sel_s && cnt != '0) begin
            nxt = CMD_WAIT;
        end else if (last) begin
            unique case (state)
                CMD_WAIT: begin
                    if (byte_bad || cmd_loop) nxt = CMD_WAIT;
                    else if (byte_in[3])      nxt = REG_READ;
                    else                      nxt = REG_WRITE;
                end
                REG_WRITE: nxt = CMD_WAIT;
                REG_READ:  nxt = CMD_WAIT;
                default:   nxt = CMD_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CMD_WAIT;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            sh      <= '0;
            rsel    <= SEL_CMD;
            gain    <= 2'b00;
            standby <= 1'b0;
            setup   <= 8'h00;
            test_q  <= 8'h00;
            sdo_q   <= 1'b0;
        end else if (!sel_s) begin
            cnt   <= '0;
            sdo_q <= 1'b0;
        end else begin
            if (rise) begin
                cnt <= last ? '0 : cnt + 1'b1;
                unique case (state)
                    CMD_WAIT: begin
                        sh <= {sh[RES_W-2:0], sdi_s};
                        if (last && !byte_bad) begin
                            rsel    <= sel_t'(byte_in[5:4]);
                            standby <= byte_in[2];
                            gain    <= byte_in[1:0];
                            if (byte_in[3]) begin
                                unique case (sel_t'(byte_in[5:4]))
                                    SEL_CMD:   sh <= {cmd_rb, {PAD{1'b0}}};
                                    SEL_SETUP: sh <= {setup,  {PAD{1'b0}}};
                                    SEL_TEST:  sh <= {test_q, {PAD{1'b0}}};
                                    SEL_RES:   sh <= res_word;
                                    default:   sh <= '0;
                                endcase
                            end
                        end
                    end
                    REG_WRITE: begin
                        sh <= {sh[RES_W-2:0], sdi_s};
                        if (last && rsel == SEL_SETUP) setup  <= byte_in;
                        if (last && rsel == SEL_TEST)  test_q <= byte_in;
                    end
                    REG_READ: sh <= {sh[RES_W-2:0], 1'b0};
                    default:  sh <= sh;
                endcase
            end
            if (fall) sdo_q <= (state == REG_READ) ? sh[RES_W-1] : 1'b0;
        end
    end

    assign sdo      = sdo_q;
    assign rd_start = (state == CMD_WAIT) && last && !byte_bad && byte_in[3] &&
                      (sel_t'(byte_in[5:4]) == SEL_RES);
    assign rd_done  = (state == REG_READ) && last && (rsel == SEL_RES);

    // R2
    bad_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CMD_WAIT && last && byte_bad) |=>
        ($stable(gain) && $stable(standby) && state == CMD_WAIT));
    // R8
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s && cnt != '0) |=> (state == CMD_WAIT && cnt == '0));
    // R9
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CMD_WAIT && last) |=> state == CMD_WAIT);
    // R7
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REG_READ && !rise) |=> $stable(sh));
    // R11
    sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == CMD_WAIT && state == CMD_WAIT && fall) |=> !sdo);
endmodule

// File: rtl/regport_top.sv
module regport_top #(
    parameter int RES_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             sdi,
    output logic             sdo,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    output logic [1:0]       gain,
    output logic             standby,
    output logic [1:0]       cal_mode,
    output logic             unipolar,
    output logic [4:0]       filt_sel
);
    logic             sdi_s, sel_s, rise, fall;
    logic             drdy, rd_start, rd_done;
    logic [RES_W-1:0] res_word;
    logic [7:0]       setup;

    regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .sdi_s(sdi_s), .sel_s(sel_s), .rise(rise), .fall(fall)
    );

    regport_result #(.RES_W(RES_W)) u_res (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_in(res_data),
        .rd_start(rd_start), .rd_done(rd_done), .drdy(drdy), .res_word(res_word)
    );

    regport_ctrl #(.RES_W(RES_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sdi_s(sdi_s), .sel_s(sel_s), .rise(rise),
        .fall(fall), .drdy(drdy), .res_word(res_word), .sdo(sdo), .gain(gain),
        .standby(standby), .setup(setup), .rd_start(rd_start), .rd_done(rd_done)
    );

    assign cal_mode = setup[7:6];
    assign unipolar = setup[5];
    assign filt_sel = setup[4:0];
endmodule

// File: tb/regport_top_tb.sv
`timescale 1ns/1ps
module regport_top_tb;
    localparam int HALF = 8;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [4:0]  nbits;
        logic [15:0] pay;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VEC [0:6] = '{
        '{8'h12, 5'd8,  16'h00C7, 16'h0000},  // R3 setup write, sdo quiet
        '{8'h1A, 5'd8,  16'h0000, 16'h00C7},  // R3 setup read
        '{8'h21, 5'd8,  16'h005A, 16'h0000},  // R4 test write
        '{8'h29, 5'd8,  16'h0000, 16'h005A},  // R4 test read
        '{8'h0D, 5'd8,  16'h0000, 16'h000D},  // R5 status read, standby+gain
        '{8'h08, 5'd8,  16'h0000, 16'h0008},  // R5 status read, plain
        '{8'h38, 5'd16, 16'h0000, 16'h0000}   // R6 result read before any result
    };
    localparam string VREQ [0:6] = '{"R3", "R3", "R4", "R4", "R5", "R5", "R6"};

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0, res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic        sdo, standby, unipolar;
    logic [1:0]  gain, cal_mode;
    logic [4:0]  filt_sel;
    int          nvec = 0, nfail = 0;
    logic [15:0] rx, ra, rb;

    always #4 clk = ~clk;

    regport_top u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
        .res_valid(res_valid), .res_data(res_data), .gain(gain), .standby(standby),
        .cal_mode(cal_mode), .unipolar(unipolar), .filt_sel(filt_sel)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] tx, input int n, output logic [15:0] got);
        got = '0;
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b0; sdi = tx[i];
            wait_clk(HALF);
            got[i] = sdo;
            sclk = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic sel(input logic v);
        cs_n = ~v;
        wait_clk(HALF);
    endtask

    task automatic frame(input logic [7:0] cmd, input int n, input logic [15:0] pay,
                         output logic [15:0] got);
        logic [15:0] dummy;
        sel(1'b1);
        xfer({8'h00, cmd}, 8, dummy);
        xfer(pay, n, got);
        sel(1'b0);
    endtask

    task automatic push(input logic [15:0] v);
        res_data = v; res_valid = 1'b1;
        wait_clk(1);
        res_valid = 1'b0;
        wait_clk(1);
    endtask

    initial begin
        #(200000 * 8);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        // R1 reset state
        check("R1", {14'd0, gain}, 16'd0);
        check("R1", {15'd0, standby}, 16'd0);
        check("R1", {8'd0, cal_mode, unipolar, filt_sel}, 16'd0);
        check("R1", {15'd0, sdo}, 16'd0);
        frame(8'h08, 8, 16'h0, rx);
        check("R1", rx, 16'h0008);

        for (int k = 0; k < 7; k++) begin
            frame(VEC[k].cmd, int'(VEC[k].nbits), VEC[k].pay, rx);
            check(VREQ[k], rx, VEC[k].exp);
        end
        // R3 field positions for 0xC7
        check("R3", {14'd0, cal_mode}, 16'd3);
        check("R3", {15'd0, unipolar}, 16'd0);
        check("R3", {11'd0, filt_sel}, 16'd7);
        check("R11", {15'd0, sdo}, 16'd0);

        // R6 plain result read clears ready
        push(16'hBEEF);
        frame(8'h08, 8, 16'h0, rx);
        check("R6", rx, 16'h0088);
        frame(8'h38, 16, 16'h0, rx);
        check("R6", rx, 16'hBEEF);
        frame(8'h08, 8, 16'h0, rx);
        check("R6", rx, 16'h0008);

        // R7 result arrives four bits into a read
        push(16'h1234);
        sel(1'b1);
        xfer(16'h0038, 8, rx);
        xfer(16'h0, 4, ra);
        push(16'h4321);
        xfer(16'h0, 12, rb);
        sel(1'b0);
        check("R7", {ra[3:0], rb[11:0]}, 16'h1234);
        frame(8'h08, 8, 16'h0, rx);
        check("R7", rx, 16'h0088);
        frame(8'h38, 16, 16'h0, rx);
        check("R7", rx, 16'h4321);
        frame(8'h08, 8, 16'h0, rx);
        check("R6", rx, 16'h0008);

        // R10 write aimed at result register
        frame(8'h30, 16, 16'hFFFF, rx);
        check("R11", rx, 16'h0000);
        frame(8'h38, 16, 16'h0, rx);
        check("R10", rx, 16'h4321);

        // R2 command fields and rejected byte
        sel(1'b1); xfer(16'h0007, 8, rx); sel(1'b0);
        check("R2", {13'd0, standby, gain}, 16'h0007);
        sel(1'b1); xfer(16'h0040, 8, rx); sel(1'b0);
        check("R2", {13'd0, standby, gain}, 16'h0007);
        frame(8'h0C, 8, 16'h0, rx);
        check("R2", rx, 16'h000C);

        // R8 abort after three bits
        sel(1'b1); xfer(16'h0007, 3, rx); sel(1'b0);
        frame(8'h1A, 8, 16'h0, rx);
        check("R8", rx, 16'h00C7);
        check("R8", {14'd0, gain}, 16'd2);

        // R9 back-to-back phases within one frame
        sel(1'b1);
        xfer(16'h0010, 8, rx);
        xfer(16'h003C, 8, rx);
        xfer(16'h0018, 8, rx);
        xfer(16'h0000, 8, rx);
        sel(1'b0);
        check("R9", rx, 16'h003C);
        check("R3", {8'd0, cal_mode, unipolar, filt_sel}, 16'h003C);
        check("R11", {15'd0, sdo}, 16'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule